// File: doc/BRIEF.md
# SIMD Lane Permutation Unit

This block rearranges the lanes of two vector operands for a SIMD datapath. A request carries two operands of up to 128 bits, an operation code, an element size and a small immediate. Each operand can be used at the full 128-bit width or as a 64-bit half, and elements can be 8, 16 or 32 bits. The block supports seven operations:

- a byte-window extract from the joined operands;
- three reversals, each bounded by a container of a given width;
- an element transpose;
- an interleave (zip);
- a de-interleave (unzip).

Transpose, zip and unzip rewrite both operands, so the block always returns two results.

All operations share one combinational lane-routing stage. A two-state holding register sits after it and gives a valid/ready handshake on each side. In state `ST_EMPTY` the block is always ready, and an **accept** moves it to `ST_FULL`. In `ST_FULL` three things can happen:

- **drain**: the consumer takes the result and no new request arrives, so the block returns to `ST_EMPTY`;
- **drain-and-refill**: the consumer takes the result while a new request is accepted in the same cycle, so the block stays in `ST_FULL`;
- **hold**: the consumer is stalled, so the stored result stays unchanged and the block accepts nothing.

Requests that are not legal are reported on a flag and pass their operands through unchanged.

Top module: `lane_permute_unit`

## Requirements

**Encodings**

- `req_op`: 0 extract, 1 reverse-in-16, 2 reverse-in-32, 3 reverse-in-64, 4 transpose, 5 zip, 6 unzip, 7 reserved.
- `req_esize`: 0 is 8 bits, 1 is 16 bits, 2 is 32 bits, 3 is reserved.
- `req_wide`: 1 selects 128-bit operands, 0 selects their low 64 bits.
- Element index 0 is always the least significant element.
- W is the active width in bits (128 when `req_wide` is 1, 64 when it is 0).

**Requirements**

- R1: Extract returns in `rsp_first` byte k equal to byte (imm+k) of the active-width concatenation `{b,a}`, where `a` forms the low half. `rsp_second` is zero and `req_esize` is ignored, including the value 3.
- R2: Extract in 64-bit mode with imm of 8 or more is illegal.
- R3: For a legal reverse with container C of 16, 32 or 64 bits, element k of `rsp_first` is element (k XOR (C/E-1)) of `a`, where E is the element size. `rsp_second` is zero.
- R4: A reverse whose element size is equal to or larger than its container is illegal.
- R5: Transpose sets element 2i of `rsp_first` to a[2i] and element 2i+1 to b[2i]. It sets element 2i of `rsp_second` to a[2i+1] and element 2i+1 to b[2i+1].
- R6: Zip interleaves the operands into the sequence a0,b0,a1,b1,… of 2N elements. `rsp_first` takes the low N elements of that sequence and `rsp_second` the high N. For example, with 8-bit elements in 64-bit mode, `rsp_first` is B3A3B2A2B1A1B0A0 and `rsp_second` is B7A7B6A6B5A5B4A4.
- R7: Unzip puts the even-indexed elements of `a` and then those of `b` in `rsp_first`, and the odd-indexed elements in the same order in `rsp_second`. For example, `rsp_first` is B6B4B2B0A6A4A2A0 and `rsp_second` is B7B5B3B1A7A5A3A1.
- R8: Handshake:
  - A result is presented with `rsp_valid` high at the clock edge that accepts the request.
  - `req_ready` is high when no result is held, or when `rsp_ready` is high.
  - A result that has not been taken stays stable.
  - `rsp_valid` falls after a drain that has no refill.
- R9: In 64-bit mode the upper 64 bits of both results are zero.
- R10: For opcode 7, or element size 3 on any operation other than extract, `rsp_illegal` is 1. For every illegal request (including those in R2 and R4), `rsp_first` is `a`, `rsp_second` is `b` (upper halves zeroed per R9), and `rsp_illegal` is 1. `rsp_illegal` is 0 for legal requests.
- R11: After reset, `rsp_valid` is 0, `req_ready` is 1, and both results and `rsp_illegal` are zero.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_op | input | 3 | Operation code |
| req_esize | input | 2 | Element size code |
| req_wide | input | 1 | 1 = 128-bit operands, 0 = 64-bit |
| req_imm | input | 4 | Extract byte offset |
| req_a | input | 128 | First operand |
| req_b | input | 128 | Second operand |
| rsp_valid | output | 1 | Result held |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_first | output | 128 | First result |
| rsp_second | output | 128 | Second result |
| rsp_illegal | output | 1 | Request was illegal; operands passed through |

## Verification

The case hardest to reach from the ports is the **drain-and-refill** transition. It happens while a result is being held under back-pressure and a second request is already waiting. The stimulus:

1. Stalls `rsp_ready` and sends one request.
2. Presents a second request that must be refused for several cycles while the first result stays frozen.
3. Releases `rsp_ready`, so that the drain and the new accept fall on the same edge.

Each operation, size and width combination is driven from a table, and every result is compared with an element-level model. The table also covers the reverse and extract encodings that sit exactly on the legality boundary.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    typedef enum logic [2:0] {
        OP_EXTRACT   = 3'd0,
        OP_REV16     = 3'd1,
        OP_REV32     = 3'd2,
        OP_REV64     = 3'd3,
        OP_TRANSPOSE = 3'd4,
        OP_ZIP       = 3'd5,
        OP_UNZIP     = 3'd6,
        OP_RSVD      = 3'd7
    } perm_op_e;

    typedef enum logic [1:0] {
        ES_B8   = 2'd0,
        ES_B16  = 2'd1,
        ES_B32  = 2'd2,
        ES_RSVD = 2'd3
    } elem_size_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } hold_state_e;

    function automatic logic op_is_dual(perm_op_e op);
        return (op == OP_TRANSPOSE) || (op == OP_ZIP) || (op == OP_UNZIP);
    endfunction

endpackage

// File: rtl/lpu_decode.sv
module lpu_decode
    import lpu_pkg::*;
#(
    parameter int IMM_W      = 4,
    parameter int NARROW_MAX = 8
) (
    input  perm_op_e         op,
    input  elem_size_e       esize,
    input  logic             wide,
    input  logic [IMM_W-1:0] imm,
    output logic             illegal,
    output logic             dual
);

    always_comb begin
        illegal = 1'b0;
        unique case (op)
            OP_EXTRACT:   illegal = !wide && (int'(imm) >= NARROW_MAX);
            OP_REV16:     illegal = (esize != ES_B8);
            OP_REV32:     illegal = (esize == ES_B32) || (esize == ES_RSVD);
            OP_REV64:     illegal = (esize == ES_RSVD);
            OP_TRANSPOSE,
            OP_ZIP,
            OP_UNZIP:     illegal = (esize == ES_RSVD);
            OP_RSVD:      illegal = 1'b1;
        endcase
        dual = op_is_dual(op);
    end

endmodule

// File: rtl/lpu_lane_route.sv
module lpu_lane_route
    import lpu_pkg::*;
#(
    parameter int VEC_W = 128,
    parameter int IMM_W = 4
) (
    input  perm_op_e         op,
    input  elem_size_e       esize,
    input  logic             wide,
    input  logic [IMM_W-1:0] imm,
    input  logic [VEC_W-1:0] a,
    input  logic [VEC_W-1:0] b,
    output logic [VEC_W-1:0] res_first,
    output logic [VEC_W-1:0] res_second
);

    localparam int HALF_W  = VEC_W / 2;
    localparam int N_SIZES = 3;

    logic [VEC_W-1:0] zip1_v [4];
    logic [VEC_W-1:0] zip2_v [4];
    logic [VEC_W-1:0] uzp1_v [4];
    logic [VEC_W-1:0] uzp2_v [4];
    logic [VEC_W-1:0] trn1_v [4];
    logic [VEC_W-1:0] trn2_v [4];
    logic [VEC_W-1:0] rv16_v [4];
    logic [VEC_W-1:0] rv32_v [4];
    logic [VEC_W-1:0] rv64_v [4];

    assign zip1_v[3] = '0;
    assign zip2_v[3] = '0;
    assign uzp1_v[3] = '0;
    assign uzp2_v[3] = '0;
    assign trn1_v[3] = '0;
    assign trn2_v[3] = '0;
    assign rv16_v[3] = '0;
    assign rv32_v[3] = '0;
    assign rv64_v[3] = '0;

    // One routing slice per element size
    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int ES  = 8 << g;
        localparam int NE  = VEC_W / ES;
        localparam int R16 = (ES < 16) ? 16 / ES : 1;
        localparam int R32 = (ES < 32) ? 32 / ES : 1;
        localparam int R64 = 64 / ES;

        logic [VEC_W-1:0] z1, z2, u1, u2, t1, t2, v16, v32, v64;

        always_comb begin
            int half;
            z1 = '0; z2 = '0; u1 = '0; u2 = '0;
            t1 = '0; t2 = '0; v16 = '0; v32 = '0; v64 = '0;
            half = wide ? NE / 2 : NE / 4;
            for (int k = 0; k < NE; k++) begin
                // interleave / de-interleave depend on active width
                if (k < 2 * half) begin
                    if ((k % 2) == 1) begin
                        z1[k*ES +: ES] = b[(k/2)*ES +: ES];
                        z2[k*ES +: ES] = b[(half + k/2)*ES +: ES];
                    end else begin
                        z1[k*ES +: ES] = a[(k/2)*ES +: ES];
                        z2[k*ES +: ES] = a[(half + k/2)*ES +: ES];
                    end
                    if (k < half) begin
                        u1[k*ES +: ES] = a[(2*k)*ES +: ES];
                        u2[k*ES +: ES] = a[(2*k+1)*ES +: ES];
                    end else begin
                        u1[k*ES +: ES] = b[(2*(k-half))*ES +: ES];
                        u2[k*ES +: ES] = b[(2*(k-half)+1)*ES +: ES];
                    end
                end
                // 2x2 transpose on element pairs
                if ((k % 2) == 1) begin
                    t1[k*ES +: ES] = b[(k-1)*ES +: ES];
                    t2[k*ES +: ES] = b[k*ES +: ES];
                end else begin
                    t1[k*ES +: ES] = a[k*ES +: ES];
                    t2[k*ES +: ES] = a[(k+1)*ES +: ES];
                end
                // container-bounded reversal
                v16[k*ES +: ES] = a[(k ^ (R16-1))*ES +: ES];
                v32[k*ES +: ES] = a[(k ^ (R32-1))*ES +: ES];
                v64[k*ES +: ES] = a[(k ^ (R64-1))*ES +: ES];
            end
        end

        assign zip1_v[g] = z1;
        assign zip2_v[g] = z2;
        assign uzp1_v[g] = u1;
        assign uzp2_v[g] = u2;
        assign trn1_v[g] = t1;
        assign trn2_v[g] = t2;
        assign rv16_v[g] = v16;
        assign rv32_v[g] = v32;
        assign rv64_v[g] = v64;
    end

    // Byte window over the joined operands
    logic [2*VEC_W-1:0] joined;
    logic [2*VEC_W-1:0] shifted;
    logic [VEC_W-1:0]   window;

    always_comb begin
        if (wide) joined = {b, a};
        else      joined = {{VEC_W{1'b0}}, b[HALF_W-1:0], a[HALF_W-1:0]};
        shifted = joined >> {imm, 3'b000};
        window  = shifted[VEC_W-1:0];
    end

    logic [1:0] es_idx;
    assign es_idx = esize;

    always_comb begin
        res_first  = '0;
        res_second = '0;
        unique case (op)
            OP_EXTRACT:   res_first = window;
            OP_REV16:     res_first = rv16_v[es_idx];
            OP_REV32:     res_first = rv32_v[es_idx];
            OP_REV64:     res_first = rv64_v[es_idx];
            OP_TRANSPOSE: begin
                res_first  = trn1_v[es_idx];
                res_second = trn2_v[es_idx];
            end
            OP_ZIP: begin
                res_first  = zip1_v[es_idx];
                res_second = zip2_v[es_idx];
            end
            OP_UNZIP: begin
                res_first  = uzp1_v[es_idx];
                res_second = uzp2_v[es_idx];
            end
            OP_RSVD: begin
                res_first  = '0;
                res_second = '0;
            end
        endcase
    end

endmodule

// File: rtl/lpu_out_fsm.sv
module lpu_out_fsm
    import lpu_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [VEC_W-1:0] in_first,
    input  logic [VEC_W-1:0] in_second,
    input  logic             in_illegal,
    input  logic             in_narrow,
    input  logic             in_dual,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [VEC_W-1:0] out_first,
    output logic [VEC_W-1:0] out_second,
    output logic             out_illegal
);

    localparam int HALF_W = VEC_W / 2;

    hold_state_e state_q, state_d;
    logic        load;
    logic        narrow_q, dual_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_EMPTY;
        else        state_q <= state_d;
    end

    // next state and handshake outputs
    always_comb begin
        state_d  = state_q;
        in_ready = 1'b1;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) state_d = ST_FULL;          // accept
            end
            ST_FULL: begin
                in_ready = out_ready;
                if (out_ready && !in_valid) state_d = ST_EMPTY; // drain
                else                        state_d = ST_FULL;  // hold / drain-and-refill
            end
        endcase
        load      = in_valid && in_ready;
        out_valid = (state_q == ST_FULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_first   <= '0;
            out_second  <= '0;
            out_illegal <= 1'b0;
            narrow_q    <= 1'b0;
            dual_q      <= 1'b0;
        end else if (load) begin
            out_first   <= in_first;
            out_second  <= in_second;
            out_illegal <= in_illegal;
            narrow_q    <= in_narrow;
            dual_q      <= in_dual;
        end
    end

    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_first) && $stable(out_second)
                                       && $stable(out_illegal)));

    p_accept_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    p_ready_when_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);

    p_narrow_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && narrow_q) |-> ((out_first[VEC_W-1:HALF_W] == '0) && (out_second[VEC_W-1:HALF_W] == '0)));

    p_single_second_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !dual_q && !out_illegal) |-> (out_second == '0));

endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lpu_pkg::*;
#(
    parameter  int VEC_W = 128,
    localparam int IMM_W = $clog2(VEC_W / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [1:0]       req_esize,
    input  logic             req_wide,
    input  logic [IMM_W-1:0] req_imm,
    input  logic [VEC_W-1:0] req_a,
    input  logic [VEC_W-1:0] req_b,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [VEC_W-1:0] rsp_first,
    output logic [VEC_W-1:0] rsp_second,
    output logic             rsp_illegal
);

    localparam int HALF_W = VEC_W / 2;

    perm_op_e         op;
    elem_size_e       esize;
    logic             illegal, dual;
    logic [VEC_W-1:0] route_first, route_second;
    logic [VEC_W-1:0] sel_first, sel_second;
    logic [VEC_W-1:0] width_mask;

    assign op    = perm_op_e'(req_op);
    assign esize = elem_size_e'(req_esize);

    lpu_decode #(.IMM_W(IMM_W), .NARROW_MAX(VEC_W / 16)) decode_i (
        .op      (op),
        .esize   (esize),
        .wide    (req_wide),
        .imm     (req_imm),
        .illegal (illegal),
        .dual    (dual)
    );

    lpu_lane_route #(.VEC_W(VEC_W), .IMM_W(IMM_W)) route_i (
        .op         (op),
        .esize      (esize),
        .wide       (req_wide),
        .imm        (req_imm),
        .a          (req_a),
        .b          (req_b),
        .res_first  (route_first),
        .res_second (route_second)
    );

    always_comb begin
        width_mask = {{HALF_W{req_wide}}, {HALF_W{1'b1}}};
        if (illegal) begin
            sel_first  = req_a;
            sel_second = req_b;
        end else begin
            sel_first  = route_first;
            sel_second = dual ? route_second : '0;
        end
        sel_first  = sel_first & width_mask;
        sel_second = sel_second & width_mask;
    end

    lpu_out_fsm #(.VEC_W(VEC_W)) hold_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (req_valid),
        .in_ready    (req_ready),
        .in_first    (sel_first),
        .in_second   (sel_second),
        .in_illegal  (illegal),
        .in_narrow   (!req_wide),
        .in_dual     (dual),
        .out_valid   (rsp_valid),
        .out_ready   (rsp_ready),
        .out_first   (rsp_first),
        .out_second  (rsp_second),
        .out_illegal (rsp_illegal)
    );

    p_reserved_op_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 3'd7)) |=> (rsp_valid && rsp_illegal
            && (rsp_first == ($past(req_a) & {{HALF_W{$past(req_wide)}}, {HALF_W{1'b1}}}))));

    p_rev16_wide_elem_illegal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (req_op == 3'd1) && (req_esize != 2'd0)) |=> rsp_illegal);

endmodule

// File: tb/lane_permute_unit_tb_top.sv
module lane_permute_unit_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_op = '0;
    logic [1:0]   req_esize = '0;
    logic         req_wide = 1'b0;
    logic [3:0]   req_imm = '0;
    logic [127:0] req_a = '0;
    logic [127:0] req_b = '0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b1;
    logic [127:0] rsp_first;
    logic [127:0] rsp_second;
    logic         rsp_illegal;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    lane_permute_unit dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_esize(req_esize), .req_wide(req_wide), .req_imm(req_imm),
        .req_a(req_a), .req_b(req_b),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_first(rsp_first), .rsp_second(rsp_second), .rsp_illegal(rsp_illegal)
    );

    // {op[2:0], esize[1:0], wide, imm[3:0]}
    localparam int N_VEC = 28;
    localparam logic [9:0] VEC_TAB [N_VEC] = '{
        {3'd0, 2'd0, 1'b1, 4'd0},  {3'd0, 2'd0, 1'b1, 4'd5},  {3'd0, 2'd1, 1'b1, 4'd15},
        {3'd0, 2'd0, 1'b0, 4'd3},  {3'd0, 2'd0, 1'b0, 4'd7},  {3'd0, 2'd0, 1'b0, 4'd9},
        {3'd0, 2'd3, 1'b1, 4'd2},
        {3'd1, 2'd0, 1'b1, 4'd0},  {3'd2, 2'd0, 1'b0, 4'd0},  {3'd2, 2'd1, 1'b1, 4'd0},
        {3'd3, 2'd0, 1'b1, 4'd0},  {3'd3, 2'd1, 1'b0, 4'd0},  {3'd3, 2'd2, 1'b1, 4'd0},
        {3'd1, 2'd1, 1'b1, 4'd0},  {3'd2, 2'd2, 1'b1, 4'd0},  {3'd3, 2'd3, 1'b0, 4'd0},
        {3'd4, 2'd0, 1'b0, 4'd0},  {3'd4, 2'd1, 1'b1, 4'd0},  {3'd4, 2'd2, 1'b1, 4'd0},
        {3'd5, 2'd0, 1'b1, 4'd0},  {3'd5, 2'd1, 1'b0, 4'd0},  {3'd5, 2'd2, 1'b1, 4'd0},
        {3'd5, 2'd2, 1'b0, 4'd0},
        {3'd6, 2'd0, 1'b1, 4'd0},  {3'd6, 2'd1, 1'b1, 4'd0},  {3'd6, 2'd2, 1'b0, 4'd0},
        {3'd7, 2'd0, 1'b1, 4'd0},  {3'd5, 2'd3, 1'b1, 4'd0}
    };

    function automatic logic [127:0] pattern(int idx, int which);
        logic [127:0] v;
        for (int i = 0; i < 16; i++) v[i*8 +: 8] = 8'(idx * 29 + which * 101 + i * 7 + 3);
        return v;
    endfunction

    function automatic logic [31:0] getel(logic [127:0] v, int idx, int ew);
        logic [127:0] m;
        m = (128'd1 << ew) - 128'd1;
        return 32'((v >> (idx * ew)) & m);
    endfunction

    function automatic logic [127:0] putel(logic [127:0] v, int idx, int ew, logic [31:0] val);
        logic [127:0] m;
        m = (128'd1 << ew) - 128'd1;
        return (v & ~(m << (idx * ew))) | ((128'(val) & m) << (idx * ew));
    endfunction

    task automatic ref_model(input int op, input int es, input bit wide, input int imm,
                             input logic [127:0] a, input logic [127:0] b,
                             output logic [127:0] e1, output logic [127:0] e2, output bit eill);
        int w, ew, n, cw, per;
        logic [31:0] seq [64];
        logic [127:0] msk;
        w  = wide ? 128 : 64;
        ew = 8 << ((es == 3) ? 0 : es);
        n  = w / ew;
        msk = wide ? {128{1'b1}} : {64'd0, {64{1'b1}}};
        e1 = '0; e2 = '0;
        eill = (op == 7) || (op != 0 && es == 3) || (op == 0 && !wide && imm > 7)
             || (op == 1 && es >= 1) || (op == 2 && es >= 2);
        if (eill) begin
            e1 = a & msk; e2 = b & msk;
        end else if (op == 0) begin
            for (int k = 0; k < w / 8; k++) begin
                int src = imm + k;
                e1 = putel(e1, k, 8, (src < w / 8) ? getel(a, src, 8) : getel(b, src - w / 8, 8));
            end
        end else if (op <= 3) begin
            cw  = 8 << op;
            per = cw / ew;
            for (int c = 0; c < w / cw; c++)
                for (int j = 0; j < per; j++)
                    e1 = putel(e1, c * per + j, ew, getel(a, c * per + per - 1 - j, ew));
        end else if (op == 4) begin
            for (int i = 0; i < n / 2; i++) begin
                e1 = putel(e1, 2*i,   ew, getel(a, 2*i, ew));
                e1 = putel(e1, 2*i+1, ew, getel(b, 2*i, ew));
                e2 = putel(e2, 2*i,   ew, getel(a, 2*i+1, ew));
                e2 = putel(e2, 2*i+1, ew, getel(b, 2*i+1, ew));
            end
        end else if (op == 5) begin
            for (int i = 0; i < n; i++) begin
                seq[2*i] = getel(a, i, ew); seq[2*i+1] = getel(b, i, ew);
            end
            for (int k = 0; k < n; k++) begin
                e1 = putel(e1, k, ew, seq[k]); e2 = putel(e2, k, ew, seq[n+k]);
            end
        end else begin
            for (int i = 0; i < n; i++) begin
                seq[i] = getel(a, i, ew); seq[n+i] = getel(b, i, ew);
            end
            for (int k = 0; k < n; k++) begin
                e1 = putel(e1, k, ew, seq[2*k]); e2 = putel(e2, k, ew, seq[2*k+1]);
            end
        end
    endtask

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(int op, int es, bit wide, bit ill);
        if (op == 0 && ill) return "R2";
        if (op >= 1 && op <= 3 && ill && es != 3) return "R4";
        if (ill) return "R10";
        case (op)
            0: return "R1";
            1, 2, 3: return "R3";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic send(input int op, input int es, input bit wide, input int imm,
                        input logic [127:0] a, input logic [127:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_op = 3'(op); req_esize = 2'(es); req_wide = wide;
        req_imm = 4'(imm); req_a = a; req_b = b;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [127:0] e1, e2, a, b;
        bit eill;
        string tag;
        int op, es, imm;
        bit wide;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 rsp_valid", 128'(rsp_valid), 128'd0);
        check("R11 req_ready", 128'(req_ready), 128'd1);
        check("R11 rsp_first", rsp_first, '0);
        check("R11 rsp_second", rsp_second, '0);
        check("R11 rsp_illegal", 128'(rsp_illegal), 128'd0);

        // table walk
        for (int t = 0; t < N_VEC; t++) begin
            op   = int'(VEC_TAB[t][9:7]);
            es   = int'(VEC_TAB[t][6:5]);
            wide = VEC_TAB[t][4];
            imm  = int'(VEC_TAB[t][3:0]);
            a = pattern(t, 0);
            b = pattern(t, 1);
            ref_model(op, es, wide, imm, a, b, e1, e2, eill);
            tag = op_tag(op, es, wide, eill);
            send(op, es, wide, imm, a, b);
            check({tag, " R8 valid"}, 128'(rsp_valid), 128'd1);
            check({tag, " first"}, rsp_first, e1);
            check({tag, " second"}, rsp_second, e2);
            check({tag, " illegal flag R10"}, 128'(rsp_illegal), 128'(eill));
            if (!wide) check("R9 upper zero", {rsp_first[127:64], rsp_second[127:64]}, '0);
        end

        // R8: drain with no refill drops valid
        @(negedge clk);
        check("R8 valid after drain", 128'(rsp_valid), 128'd0);

        // Back-pressure then drain-and-refill, 8-bit lanes in 64-bit mode
        a = 128'h0000_0000_0000_0000_A7A6_A5A4_A3A2_A1A0;
        b = 128'h0000_0000_0000_0000_B7B6_B5B4_B3B2_B1B0;
        @(negedge clk);
        rsp_ready = 1'b0;
        send(5, 0, 1'b0, 0, a, b);
        req_valid = 1'b1; req_op = 3'd6; req_esize = 2'd0; req_wide = 1'b0;
        req_imm = '0; req_a = a; req_b = b;
        check("R6 zip first", rsp_first, 128'hB3A3_B2A2_B1A1_B0A0);
        check("R8 ready low while held", 128'(req_ready), 128'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 held valid", 128'(rsp_valid), 128'd1);
        check("R6 zip first held R8", rsp_first, 128'hB3A3_B2A2_B1A1_B0A0);
        check("R6 zip second held R8", rsp_second, 128'hB7A7_B6A6_B5A5_B4A4);
        check("R8 ready still low", 128'(req_ready), 128'd0);
        rsp_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 refill valid", 128'(rsp_valid), 128'd1);
        check("R7 unzip first", rsp_first, 128'hB6B4_B2B0_A6A4_A2A0);
        check("R7 unzip second", rsp_second, 128'hB7B5_B3B1_A7A5_A3A1);
        @(negedge clk);
        check("R8 empty after drain", 128'(rsp_valid), 128'd0);

        // R4 boundary: reverse-in-32 with 32-bit elements passes through
        a = pattern(40, 0); b = pattern(40, 1);
        send(2, 2, 1'b0, 0, a, b);
        check("R4 rev32 es32 first", rsp_first, {64'd0, a[63:0]});
        check("R4 rev32 es32 flag", 128'(rsp_illegal), 128'd1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule